// File: doc/BRIEF.md
# Floating-point to 64-bit integer converter

This unit turns a half-, single- or double-precision floating-point operand into a 64-bit integer. A mode input picks a two's-complement or an unsigned result. The fractional part is always dropped, so the conversion truncates toward zero. Inputs that fall outside the result range, infinities and NaNs do not raise flags. Each of them produces a fixed replacement value, chosen by a fixed priority.

The operand, the format code and the mode are captured in input registers on one clock edge. The converted value is captured in the output register on the next edge. Inside that single cycle the unit does the following in order. It decodes the fields of the selected format and restores the implicit leading one. It shifts the significand left or right to the integer position. It negates the value for negative inputs in signed mode. Last, it applies the saturation rules. A new operand may be presented on every cycle.

Top module: `fp2int_conv`

## Requirements
- R1: The result appears on `result_o` after the second rising edge that follows the cycle in which the operand is presented. While `rst_n` is low, `result_o` is zero.
- R2: `fmt_i` selects the format. Code 0 is half precision, taken from operand bits [15:0]. Code 1 is single precision, taken from bits [31:0]. Codes 2 and 3 are both double precision, taken from all 64 bits. Operand bits above the selected format have no effect on the result.
- R3: Every format has sign, exponent and fraction fields in the standard layout. The implicit one is restored only when the exponent field is nonzero. Finite values are truncated toward zero, so any magnitude below one gives zero. This includes subnormals and both signed zeros.
- R4: For double precision with a biased exponent of 1087 to 1089, the aligned significand keeps only its low 64 bits. For example, 1.5×2^64 gives 0x8000000000000000 in unsigned mode.
- R5: In signed mode (`signed_i`=1), a negative input gives the two's-complement negation of its truncated magnitude. For example, -2.5 gives 0xFFFFFFFFFFFFFFFE.
- R6: In signed mode, a nonzero result whose bit 63 differs from the input sign is replaced by 0x7FFFFFFFFFFFFFFF.
- R7: Exponent overflow means a biased exponent above 1089 for double, above 190 for single, or equal to 31 for half. In signed mode, exponent overflow gives 0x8000000000000000 for negative inputs and 0x7FFFFFFFFFFFFFFF for positive inputs.
- R8: In unsigned mode (`signed_i`=0), any input with its sign bit set gives zero.
- R9: In unsigned mode, a positive input with exponent overflow gives 0xFFFFFFFFFFFFFFFF.
- R10: A NaN (exponent all ones, fraction nonzero) gives zero in both modes, whatever its sign. This rule overrides every other rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| operand_i | input | 64 | Floating-point operand, right-aligned for the narrower formats |
| fmt_i | input | 2 | Format code: 0 half, 1 single, 2 or 3 double |
| signed_i | input | 1 | 1 for a signed result, 0 for an unsigned result |
| result_o | output | 64 | Registered integer result |

## Verification
Two rules can apply in the same cycle. A NaN always has an all-ones exponent, so it also meets the exponent-overflow condition and would otherwise saturate. The bench applies quiet NaNs in both modes, and a NaN with its sign bit set. A NaN result counts as correct only if it is zero, never a saturation constant. The checker asserts the same NaN-gives-zero relation on every cycle. A second overlap occurs when a negative input's negated magnitude flips bit 63. The bench drives -1.5×2^63, whose expected result is the positive limit.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;

    localparam int RES_W    = 64;
    localparam int SIG_W    = 53;
    localparam int SHIFT_W  = 13;
    localparam int SHAMT_W  = $clog2(RES_W);
    localparam int NUM_FMT  = 3;

    typedef enum logic [1:0] {
        FMT_HALF       = 2'd0,
        FMT_SINGLE     = 2'd1,
        FMT_DOUBLE     = 2'd2,
        FMT_DOUBLE_ALT = 2'd3
    } fmt_e;

    typedef struct packed {
        logic                      sign;
        logic                      nan;
        logic                      ovf;
        logic signed [SHIFT_W-1:0] shift;
        logic [SIG_W-1:0]          sig;
    } fld_t;

    function automatic int fmt_exp_w(int f);
        case (f)
            0:       return 5;
            1:       return 8;
            default: return 11;
        endcase
    endfunction

    function automatic int fmt_man_w(int f);
        case (f)
            0:       return 10;
            1:       return 23;
            default: return 52;
        endcase
    endfunction

    function automatic int fmt_bias(int f);
        case (f)
            0:       return 15;
            1:       return 127;
            default: return 1023;
        endcase
    endfunction

    function automatic int fmt_ovf_lim(int f);
        case (f)
            0:       return 30;
            1:       return 190;
            default: return 1089;
        endcase
    endfunction

endpackage

// File: rtl/fp2int_field_dec.sv
module fp2int_field_dec
    import fp2int_pkg::*;
#(
    parameter int EXP_W   = 11,
    parameter int MAN_W   = 52,
    parameter int BIAS    = 1023,
    parameter int OVF_LIM = 1089
) (
    input  logic [EXP_W+MAN_W:0] bits_i,
    output fld_t                 info_o
);
    localparam int POINT = BIAS + MAN_W;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             hidden;
    logic [EXP_W-1:0] exp_eff;

    assign exp_f   = bits_i[EXP_W+MAN_W-1:MAN_W];
    assign man_f   = bits_i[MAN_W-1:0];
    assign hidden  = |exp_f;
    assign exp_eff = hidden ? exp_f : EXP_W'(1);

    always_comb begin
        info_o.sign  = bits_i[EXP_W+MAN_W];
        info_o.nan   = (&exp_f) && (|man_f);
        info_o.ovf   = (32'(exp_f) > OVF_LIM);
        info_o.shift = $signed({{(SHIFT_W-EXP_W){1'b0}}, exp_eff})
                     - $signed(SHIFT_W'(POINT));
        info_o.sig   = SIG_W'({hidden, man_f});
    end
endmodule

// File: rtl/fp2int_align.sv
module fp2int_align
    import fp2int_pkg::*;
(
    input  logic [SIG_W-1:0]          sig_i,
    input  logic signed [SHIFT_W-1:0] shift_i,
    output logic [RES_W-1:0]          mag_o
);
    logic [SHIFT_W-1:0] rsh;

    always_comb begin
        rsh   = -shift_i;
        mag_o = '0;
        if (!shift_i[SHIFT_W-1]) begin
            if (shift_i < $signed(SHIFT_W'(RES_W)))
                mag_o = RES_W'(sig_i) << shift_i[SHAMT_W-1:0];
        end else if (rsh < SHIFT_W'(RES_W)) begin
            mag_o = RES_W'(sig_i) >> rsh[SHAMT_W-1:0];
        end
    end
endmodule

// File: rtl/fp2int_saturate.sv
module fp2int_saturate
    import fp2int_pkg::*;
(
    input  logic [RES_W-1:0] mag_i,
    input  logic             sign_i,
    input  logic             nan_i,
    input  logic             ovf_i,
    input  logic             signed_i,
    output logic [RES_W-1:0] res_o
);
    localparam logic [RES_W-1:0] MAX_POS = {1'b0, {(RES_W-1){1'b1}}};
    localparam logic [RES_W-1:0] MIN_NEG = {1'b1, {(RES_W-1){1'b0}}};
    localparam logic [RES_W-1:0] ALL_ONE = '1;

    always_comb begin
        if (signed_i) begin
            res_o = sign_i ? (~mag_i + RES_W'(1)) : mag_i;
            if ((res_o != '0) && (res_o[RES_W-1] != sign_i)) res_o = MAX_POS;
            if (ovf_i) res_o = MIN_NEG;
            if (ovf_i && !sign_i) res_o = MAX_POS;
        end else begin
            res_o = mag_i;
            if (sign_i) res_o = '0;
            if (ovf_i && !sign_i) res_o = ALL_ONE;
        end
        if (nan_i) res_o = '0;
    end
endmodule

// File: rtl/fp2int_conv.sv
module fp2int_conv
    import fp2int_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RES_W-1:0] operand_i,
    input  logic [1:0]       fmt_i,
    input  logic             signed_i,
    output logic [RES_W-1:0] result_o
);
    logic [RES_W-1:0] opnd_q;
    fmt_e             fmt_q;
    logic             sgn_q;
    fld_t             dec [NUM_FMT];
    fld_t             sel;
    logic [RES_W-1:0] mag;
    logic [RES_W-1:0] res_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opnd_q <= '0;
            fmt_q  <= FMT_DOUBLE;
            sgn_q  <= 1'b0;
        end else begin
            opnd_q <= operand_i;
            fmt_q  <= fmt_e'(fmt_i);
            sgn_q  <= signed_i;
        end
    end

    for (genvar f = 0; f < NUM_FMT; f++) begin : g_dec
        localparam int EW = fmt_exp_w(f);
        localparam int MW = fmt_man_w(f);
        fp2int_field_dec #(
            .EXP_W  (EW),
            .MAN_W  (MW),
            .BIAS   (fmt_bias(f)),
            .OVF_LIM(fmt_ovf_lim(f))
        ) u_dec (
            .bits_i(opnd_q[EW+MW:0]),
            .info_o(dec[f])
        );
    end

    always_comb begin
        unique case (fmt_q)
            FMT_HALF:   sel = dec[0];
            FMT_SINGLE: sel = dec[1];
            default:    sel = dec[2];
        endcase
    end

    fp2int_align u_align (
        .sig_i  (sel.sig),
        .shift_i(sel.shift),
        .mag_o  (mag)
    );

    fp2int_saturate u_sat (
        .mag_i   (mag),
        .sign_i  (sel.sign),
        .nan_i   (sel.nan),
        .ovf_i   (sel.ovf),
        .signed_i(sgn_q),
        .res_o   (res_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) result_o <= '0;
        else        result_o <= res_d;
    end
endmodule

// File: rtl/fp2int_conv_chk.sv
module fp2int_conv_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] operand_i,
    input logic [1:0]  fmt_i,
    input logic        signed_i,
    input logic [63:0] result_o
);
    logic in_sign;
    logic in_nan;
    logic half_exp_full;

    always_comb begin
        case (fmt_i)
            2'd0: begin
                in_sign = operand_i[15];
                in_nan  = (&operand_i[14:10]) && (|operand_i[9:0]);
            end
            2'd1: begin
                in_sign = operand_i[31];
                in_nan  = (&operand_i[30:23]) && (|operand_i[22:0]);
            end
            default: begin
                in_sign = operand_i[63];
                in_nan  = (&operand_i[62:52]) && (|operand_i[51:0]);
            end
        endcase
        half_exp_full = &operand_i[14:10];
    end

    AST_NAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        in_nan |-> ##2 (result_o == 64'd0)); // R10

    AST_UNSIGNED_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!signed_i && in_sign) |-> ##2 (result_o == 64'd0)); // R8

    AST_SIGNED_POS_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (signed_i && !in_sign) |-> ##2 (result_o[63] == 1'b0)); // R6

    AST_SIGNED_NEG_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (signed_i && in_sign && !in_nan) |-> ##2
        (result_o[63] || result_o == 64'd0 || result_o == 64'h7FFF_FFFF_FFFF_FFFF)); // R5

    AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_i == 2'd0 && !signed_i && !half_exp_full) |-> ##2 (result_o <= 64'd65504)); // R2
endmodule

bind fp2int_conv fp2int_conv_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .operand_i(operand_i),
    .fmt_i    (fmt_i),
    .signed_i (signed_i),
    .result_o (result_o)
);

// File: tb/tb_fp2int_conv.sv
module tb_fp2int_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] operand_i = '0;
    logic [1:0]  fmt_i = 2'd2;
    logic        signed_i = 1'b0;
    logic [63:0] result_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    always #10 clk = ~clk;

    fp2int_conv dut (
        .clk(clk), .rst_n(rst_n), .operand_i(operand_i),
        .fmt_i(fmt_i), .signed_i(signed_i), .result_o(result_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic conv(input logic [1:0] f, input logic s, input logic [63:0] op,
                        input logic [63:0] exp, input string req);
        @(negedge clk);
        operand_i = op; fmt_i = f; signed_i = s;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(req, result_o, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 reset", result_o, 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_latency;
        // R1: value present after exactly two edges, old value before
        conv(2'd2, 1'b0, 64'h3FF0_0000_0000_0000, 64'd1, "R1 first");
        @(negedge clk);
        operand_i = 64'h405E_F000_0000_0000;
        @(posedge clk); @(negedge clk);
        check("R1 one edge", result_o, 64'd1);
        @(posedge clk); @(negedge clk);
        check("R1 two edges", result_o, 64'd123);
    endtask

    task automatic t_truncate;
        conv(2'd2, 1'b0, 64'h3FE8_0000_0000_0000, 64'd0, "R3 0.75");
        conv(2'd2, 1'b1, 64'h0000_0000_0000_0001, 64'd0, "R3 subnormal");
        conv(2'd2, 1'b1, 64'h8000_0000_0000_0000, 64'd0, "R3 neg zero");
        conv(2'd0, 1'b0, 64'h0000_0000_0000_3800, 64'd0, "R3 half 0.5");
        conv(2'd2, 1'b0, 64'h4330_0000_0000_0001, 64'h0010_0000_0000_0001, "R3 2^52+1");
        conv(2'd2, 1'b0, 64'h43D0_0000_0000_0001, 64'h4000_0000_0000_0400, "R3 left shift");
        conv(2'd1, 1'b0, 64'h0000_0000_53C0_0000, 64'h0000_0180_0000_0000, "R3 single 1.5*2^40");
        conv(2'd1, 1'b0, 64'h0000_0000_4B80_0000, 64'h0000_0000_0100_0000, "R3 single 2^24");
    endtask

    task automatic t_formats;
        conv(2'd1, 1'b0, 64'hFFFF_FFFF_3F80_0000, 64'd1, "R2 single upper ignored");
        conv(2'd0, 1'b0, 64'hABCD_1234_5678_7BFF, 64'h0000_0000_0000_FFE0, "R2 half max");
        conv(2'd3, 1'b0, 64'h3FF0_0000_0000_0000, 64'd1, "R2 code3 double");
    endtask

    task automatic t_wrap;
        conv(2'd2, 1'b0, 64'h43F8_0000_0000_0000, MINN, "R4 wrap unsigned");
        conv(2'd2, 1'b0, 64'h43E0_0000_0000_0000, MINN, "R4 2^63 unsigned");
    endtask

    task automatic t_signed;
        conv(2'd2, 1'b1, 64'hC004_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFE, "R5 -2.5");
        conv(2'd1, 1'b1, 64'h0000_0000_C0F0_0000, 64'hFFFF_FFFF_FFFF_FFF9, "R5 single -7.5");
        conv(2'd0, 1'b1, 64'h0000_0000_0000_C380, 64'hFFFF_FFFF_FFFF_FFFD, "R5 half -3.75");
        conv(2'd2, 1'b1, 64'hC3D0_0000_0000_0001, 64'hBFFF_FFFF_FFFF_FC00, "R5 big neg");
        conv(2'd2, 1'b1, 64'hC3E0_0000_0000_0000, MINN, "R5 -2^63 exact");
        conv(2'd2, 1'b1, 64'h43E0_0000_0000_0000, MAXP, "R6 +2^63");
        conv(2'd2, 1'b1, 64'hC3E8_0000_0000_0000, MAXP, "R6 -1.5*2^63");
        conv(2'd1, 1'b1, 64'h0000_0000_5F00_0000, MAXP, "R6 single 2^63");
    endtask

    task automatic t_overflow;
        conv(2'd2, 1'b1, 64'h4420_0000_0000_0000, MAXP, "R7 pos ovf");
        conv(2'd2, 1'b1, 64'hC420_0000_0000_0000, MINN, "R7 neg ovf");
        conv(2'd1, 1'b1, 64'h0000_0000_DF80_0000, MINN, "R7 single neg ovf");
        conv(2'd0, 1'b1, 64'h0000_0000_0000_FC00, MINN, "R7 half -inf");
        conv(2'd0, 1'b1, 64'h0000_0000_0000_7C00, MAXP, "R7 half +inf");
        conv(2'd2, 1'b1, 64'h7FF0_0000_0000_0000, MAXP, "R7 +inf");
    endtask

    task automatic t_unsigned;
        conv(2'd2, 1'b0, 64'hC004_0000_0000_0000, 64'd0, "R8 -2.5");
        conv(2'd1, 1'b0, 64'h0000_0000_DF80_0000, 64'd0, "R8 single neg ovf");
        conv(2'd2, 1'b0, 64'h4420_0000_0000_0000, ONES, "R9 pos ovf");
        conv(2'd1, 1'b0, 64'h0000_0000_5F80_0000, ONES, "R9 single 2^64");
        conv(2'd0, 1'b0, 64'h0000_0000_0000_7C00, ONES, "R9 half +inf");
    endtask

    task automatic t_nan;
        conv(2'd2, 1'b1, 64'h7FF8_0000_0000_0000, 64'd0, "R10 signed nan");
        conv(2'd2, 1'b0, 64'h7FF8_0000_0000_0000, 64'd0, "R10 unsigned nan");
        conv(2'd2, 1'b1, 64'hFFF8_0000_0000_0000, 64'd0, "R10 neg nan");
        conv(2'd1, 1'b1, 64'h0000_0000_7FC0_0000, 64'd0, "R10 single nan");
        conv(2'd0, 1'b0, 64'h0000_0000_0000_7E00, 64'd0, "R10 half nan");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_latency();
        t_truncate();
        t_formats();
        t_wrap();
        t_signed();
        t_overflow();
        t_unsigned();
        t_nan();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule